// File: doc/BRIEF.md
# Destructive-Read Byte Memory Controller

This block runs the memory opcodes of a microcoded machine against an internal 1024-byte array. The array behaves like destructive-read core: a read hands the byte to two nibble buffers and leaves zero in the location. A write never overwrites. It loads one nibble of the ALU result into a buffer and then XORs the full buffer byte into the addressed location. The cleared location from an earlier read therefore ends up holding exactly the buffer byte.

The block holds the 10-bit address register. The address is built from a 2-bit high part, a 4-bit middle part and a 4-bit low part. Two addressing styles exist:
- the two low bits of T, with U and V, form the address;
- the high part is forced to ones, the middle part comes from the microword constant, and the low part comes from V.

Some reads also hand the buffers to the working registers CA and CB. The opcodes that do not touch memory are decoded into one-cycle strobes for the peripheral logic around the block. A cycle strobe qualifies every opcode.

Top module: `core_byte_mem_ctrl`

## Requirements
- R1: After reset, `ra`, `rb` and `mem_addr` are zero, `ca_we`, `cb_we`, `bad_op` and `ctl_stb` are low, and every memory byte reads back as 0x00.
- R2: With `cyc_en` high and `op` 0010 or 0011, the next cycle shows `mem_addr` = {`t_lo`, `u_val`, `v_val`}, `ra` = bits 7:4 and `rb` = bits 3:0 of the byte previously stored there.
- R3: With `cyc_en` high and `op` 0100 or 0101, the next cycle shows `mem_addr` = {2'b11, `kk`, `v_val`}, and `ra`/`rb` hold the stored byte as in R2.
- R4: Every read (ops 0010 to 0101) leaves 0x00 in the location it read, so an immediate second read of it returns zero.
- R5: `ca_we` and `cb_we` pulse high for exactly the one cycle after an enabled op 0010 or 0100, while `ca_data` = `ra` and `cb_data` = `rb`. They stay low after ops 0011 and 0101.
- R6: Op 0000 sets `ra` to `z_bus`, keeps `rb` and `mem_addr`, and XORs {`z_bus`, old `rb`} into the byte at `mem_addr`.
- R7: Op 0001 sets `rb` to `z_bus`, keeps `ra` and `mem_addr`, and XORs {old `ra`, `z_bus`} into the byte at `mem_addr`.
- R8: Peripheral opcodes pulse one bit of `ctl_stb` for one cycle and change no buffer, address or memory byte. The opcode-to-bit mapping is: 0110 to bit0, 0111 to bit1, 1001 to bit2, 1010 to bit3, 1011 to bit4, 1100 to bit5, 1101 to bit6. Op 1000 raises no strobe.
- R9: Ops 1110 and 1111 pulse `bad_op` for one cycle and change nothing else.
- R10: While `cyc_en` is low, no output register, address or memory byte changes, and no strobe, `bad_op` or copy pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Cycle strobe qualifying `op` |
| op | input | 4 | Memory-operation opcode |
| t_lo | input | 2 | Low two bits of T (high address part) |
| u_val | input | 4 | U register value (middle address part) |
| v_val | input | 4 | V register value (low address part) |
| kk | input | 4 | Microword constant (middle address part, forced-high mode) |
| z_bus | input | 4 | ALU result nibble |
| ra | output | 4 | High-nibble buffer |
| rb | output | 4 | Low-nibble buffer |
| mem_addr | output | 10 | Address register |
| ca_we | output | 1 | Load pulse for CA |
| ca_data | output | 4 | Data for CA |
| cb_we | output | 1 | Load pulse for CB |
| cb_data | output | 4 | Data for CB |
| ctl_stb | output | 7 | Peripheral strobes, one-hot or zero |
| bad_op | output | 1 | Unassigned-opcode pulse |

## Verification
The bound checker watches on every cycle the address formed by each read style, the buffer updates of the two write opcodes, the copy and unassigned-opcode pulses, and that idle or peripheral cycles leave buffers and address untouched. What the checker cannot see is the array content. The zero left behind by a destructive read, the XOR merge of a write, and the reset-time clearing show up only when a later read in a bench scenario returns the byte. The bench therefore drives random opcodes over a small pool of addresses, so that reads and writes collide often, and compares each result against its own model.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int NIB_W  = 4;
  localparam int HI_W   = 2;
  localparam int ADDR_W = HI_W + 2 * NIB_W;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int OP_W   = 4;
  localparam int N_STB  = 7;

  typedef enum logic [OP_W-1:0] {
    OP_WR_HI     = 4'h0,
    OP_WR_LO     = 4'h1,
    OP_RD_TUV_CP = 4'h2,
    OP_RD_TUV    = 4'h3,
    OP_RD_KV_CP  = 4'h4,
    OP_RD_KV     = 4'h5,
    OP_PER_IN    = 4'h6,
    OP_PER_OUT   = 4'h7,
    OP_IDLE      = 4'h8,
    OP_Q_FLIP    = 4'h9,
    OP_TAPE_RD   = 4'hA,
    OP_TAPE_SET  = 4'hB,
    OP_MOT_ON    = 4'hC,
    OP_MOT_OFF   = 4'hD,
    OP_RSV_E     = 4'hE,
    OP_RSV_F     = 4'hF
  } mop_e;

  typedef struct packed {
    logic             wr_hi;
    logic             wr_lo;
    logic             rd_tuv;
    logic             rd_kv;
    logic             copy;
    logic             bad;
    logic [N_STB-1:0] stb;
  } mctl_t;
endpackage

// File: rtl/cbm_rst_sync.sv
module cbm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/cbm_decode.sv
module cbm_decode
  import cbm_pkg::*;
(
  input  logic            en,
  input  logic [OP_W-1:0] op,
  output mctl_t           ctl
);
  localparam logic [OP_W-1:0] STB_CODE [N_STB] = '{
    OP_PER_IN, OP_PER_OUT, OP_Q_FLIP, OP_TAPE_RD,
    OP_TAPE_SET, OP_MOT_ON, OP_MOT_OFF
  };

  logic [N_STB-1:0] stb_hit;

  for (genvar g = 0; g < N_STB; g++) begin : g_stb
    assign stb_hit[g] = en && (op == STB_CODE[g]);
  end

  always_comb begin
    ctl        = '0;
    ctl.stb    = stb_hit;
    if (en) begin
      unique case (mop_e'(op))
        OP_WR_HI:     ctl.wr_hi  = 1'b1;
        OP_WR_LO:     ctl.wr_lo  = 1'b1;
        OP_RD_TUV_CP: begin ctl.rd_tuv = 1'b1; ctl.copy = 1'b1; end
        OP_RD_TUV:    ctl.rd_tuv = 1'b1;
        OP_RD_KV_CP:  begin ctl.rd_kv = 1'b1; ctl.copy = 1'b1; end
        OP_RD_KV:     ctl.rd_kv  = 1'b1;
        OP_RSV_E,
        OP_RSV_F:     ctl.bad    = 1'b1;
        default:      ;
      endcase
    end
  end
endmodule

// File: rtl/cbm_addr_reg.sv
module cbm_addr_reg
  import cbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_tuv,
  input  logic              ld_kv,
  input  logic [HI_W-1:0]   t_lo,
  input  logic [NIB_W-1:0]  u_val,
  input  logic [NIB_W-1:0]  v_val,
  input  logic [NIB_W-1:0]  kk,
  output logic [ADDR_W-1:0] addr_nxt,
  output logic [ADDR_W-1:0] addr_q
);
  logic [HI_W-1:0]  hi_nxt, hi_q;
  logic [NIB_W-1:0] mid_nxt, mid_q, lo_nxt, lo_q;
  logic             ld;

  assign ld = ld_tuv | ld_kv;

  always_comb begin
    hi_nxt  = hi_q;
    mid_nxt = mid_q;
    lo_nxt  = lo_q;
    if (ld_tuv) begin
      hi_nxt  = t_lo;
      mid_nxt = u_val;
      lo_nxt  = v_val;
    end else if (ld_kv) begin
      hi_nxt  = '1;
      mid_nxt = kk;
      lo_nxt  = v_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= '0;
      mid_q <= '0;
      lo_q  <= '0;
    end else if (ld) begin
      hi_q  <= hi_nxt;
      mid_q <= mid_nxt;
      lo_q  <= lo_nxt;
    end
  end

  assign addr_nxt = {hi_nxt, mid_nxt, lo_nxt};
  assign addr_q   = {hi_q, mid_q, lo_q};
endmodule

// File: rtl/cbm_store.sv
module cbm_store
  import cbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_xor
);
  logic [BYTE_W-1:0] cell_q [DEPTH];

  assign rd_data = cell_q[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cell_q[i] <= '0;
    end else begin
      if (rd_en) cell_q[rd_addr] <= '0;
      if (wr_en) cell_q[wr_addr] <= cell_q[wr_addr] ^ wr_xor;
    end
  end
endmodule

// File: rtl/core_byte_mem_ctrl.sv
module core_byte_mem_ctrl
  import cbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic [OP_W-1:0]   op,
  input  logic [HI_W-1:0]   t_lo,
  input  logic [NIB_W-1:0]  u_val,
  input  logic [NIB_W-1:0]  v_val,
  input  logic [NIB_W-1:0]  kk,
  input  logic [NIB_W-1:0]  z_bus,
  output logic [NIB_W-1:0]  ra,
  output logic [NIB_W-1:0]  rb,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              ca_we,
  output logic [NIB_W-1:0]  ca_data,
  output logic              cb_we,
  output logic [NIB_W-1:0]  cb_data,
  output logic [N_STB-1:0]  ctl_stb,
  output logic              bad_op
);
  logic              rst_i_n;
  mctl_t             ctl;
  logic [ADDR_W-1:0] addr_nxt, addr_q;
  logic [BYTE_W-1:0] rd_byte, wr_xor;
  logic [NIB_W-1:0]  ra_q, rb_q, ra_nxt, rb_nxt;
  logic              buf_en, rd_any, wr_any;
  logic              copy_q, bad_q;
  logic [N_STB-1:0]  stb_q;

  cbm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  cbm_decode u_dec (
    .en  (cyc_en),
    .op  (op),
    .ctl (ctl)
  );

  cbm_addr_reg u_addr (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .ld_tuv   (ctl.rd_tuv),
    .ld_kv    (ctl.rd_kv),
    .t_lo     (t_lo),
    .u_val    (u_val),
    .v_val    (v_val),
    .kk       (kk),
    .addr_nxt (addr_nxt),
    .addr_q   (addr_q)
  );

  assign rd_any = ctl.rd_tuv | ctl.rd_kv;
  assign wr_any = ctl.wr_hi | ctl.wr_lo;
  assign buf_en = rd_any | wr_any;

  always_comb begin
    ra_nxt = ra_q;
    rb_nxt = rb_q;
    if (rd_any) begin
      ra_nxt = rd_byte[BYTE_W-1:NIB_W];
      rb_nxt = rd_byte[NIB_W-1:0];
    end else if (ctl.wr_hi) begin
      ra_nxt = z_bus;
    end else if (ctl.wr_lo) begin
      rb_nxt = z_bus;
    end
  end

  assign wr_xor = {ra_nxt, rb_nxt};

  cbm_store u_store (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .rd_en   (rd_any),
    .rd_addr (addr_nxt),
    .rd_data (rd_byte),
    .wr_en   (wr_any),
    .wr_addr (addr_q),
    .wr_xor  (wr_xor)
  );

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ra_q <= '0;
      rb_q <= '0;
    end else if (buf_en) begin
      ra_q <= ra_nxt;
      rb_q <= rb_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      copy_q <= 1'b0;
      bad_q  <= 1'b0;
      stb_q  <= '0;
    end else begin
      copy_q <= ctl.copy;
      bad_q  <= ctl.bad;
      stb_q  <= ctl.stb;
    end
  end

  assign ra       = ra_q;
  assign rb       = rb_q;
  assign mem_addr = addr_q;
  assign ca_we    = copy_q;
  assign cb_we    = copy_q;
  assign ca_data  = ra_q;
  assign cb_data  = rb_q;
  assign ctl_stb  = stb_q;
  assign bad_op   = bad_q;
endmodule

// File: rtl/core_byte_mem_ctrl_chk.sv
module core_byte_mem_ctrl_chk
  import cbm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cyc_en,
  input logic [OP_W-1:0]   op,
  input logic [HI_W-1:0]   t_lo,
  input logic [NIB_W-1:0]  u_val,
  input logic [NIB_W-1:0]  v_val,
  input logic [NIB_W-1:0]  kk,
  input logic [NIB_W-1:0]  z_bus,
  input logic [NIB_W-1:0]  ra,
  input logic [NIB_W-1:0]  rb,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              ca_we,
  input logic [NIB_W-1:0]  ca_data,
  input logic              cb_we,
  input logic [NIB_W-1:0]  cb_data,
  input logic [N_STB-1:0]  ctl_stb,
  input logic              bad_op
);
  logic [1:0] up_cnt;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end
  assign armed = (up_cnt == 2'd3);

  assert_tuv_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(cyc_en && (op == 4'h2 || op == 4'h3)))
      |-> mem_addr == {$past(t_lo), $past(u_val), $past(v_val)});

  assert_kv_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(cyc_en && (op == 4'h4 || op == 4'h5)))
      |-> mem_addr == {2'b11, $past(kk), $past(v_val)});

  assert_copy_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (ca_we == $past(cyc_en && (op == 4'h2 || op == 4'h4))) && (cb_we == ca_we));

  assert_copy_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ca_we |-> (ca_data == ra) && (cb_data == rb));

  assert_wr_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(cyc_en && op == 4'h0))
      |-> (ra == $past(z_bus)) && $stable(rb) && $stable(mem_addr));

  assert_wr_lo_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(cyc_en && op == 4'h1))
      |-> (rb == $past(z_bus)) && $stable(ra) && $stable(mem_addr));

  assert_stb_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl_stb));

  assert_stb_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(cyc_en && op[3:1] != 3'b000 && op[3:1] != 3'b001
                   && op[3:1] != 3'b010 && op[3:1] != 3'b111))
      |-> $stable(ra) && $stable(rb) && $stable(mem_addr) && !ca_we && !bad_op);

  assert_bad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> bad_op == $past(cyc_en && op[3:1] == 3'b111));

  assert_bad_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |-> $stable(ra) && $stable(rb) && $stable(mem_addr) && (ctl_stb == '0));

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(cyc_en))
      |-> $stable(ra) && $stable(rb) && $stable(mem_addr)
          && (ctl_stb == '0) && !bad_op && !ca_we);
endmodule

bind core_byte_mem_ctrl core_byte_mem_ctrl_chk u_chk (.*);

// File: tb/core_byte_mem_ctrl_tb.sv
`timescale 1ns/1ps
module core_byte_mem_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cyc_en;
  logic [3:0] op;
  logic [1:0] t_lo;
  logic [3:0] u_val, v_val, kk, z_bus;
  logic [3:0] ra, rb, ca_data, cb_data;
  logic [9:0] mem_addr;
  logic       ca_we, cb_we, bad_op;
  logic [6:0] ctl_stb;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  int m_mem [1024];
  int m_ra, m_rb, m_addr;

  always #2 clk = ~clk;

  core_byte_mem_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .op(op), .t_lo(t_lo),
    .u_val(u_val), .v_val(v_val), .kk(kk), .z_bus(z_bus),
    .ra(ra), .rb(rb), .mem_addr(mem_addr), .ca_we(ca_we), .ca_data(ca_data),
    .cb_we(cb_we), .cb_data(cb_data), .ctl_stb(ctl_stb), .bad_op(bad_op)
  );

  task automatic chk(string tag, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s got=%0h exp=%0h", tag, what, got, exp);
    end
  endtask

  function automatic string tag_of(bit en, int o);
    if (!en) return "R10";
    case (o)
      0: return "R6";
      1: return "R7";
      2, 3: return "R2";
      4, 5: return "R3";
      14, 15: return "R9";
      default: return "R8";
    endcase
  endfunction

  function automatic int stb_of(bit en, int o);
    if (!en) return 0;
    case (o)
      6: return 1; 7: return 2; 9: return 4; 10: return 8;
      11: return 16; 12: return 32; 13: return 64;
      default: return 0;
    endcase
  endfunction

  task automatic step(bit en, int o, int t, int u, int v, int k, int z, string tg = "");
    int e_cp;
    string tag;
    tag = (tg == "") ? tag_of(en, o) : tg;
    cyc_en = en; op = 4'(o); t_lo = 2'(t); u_val = 4'(u);
    v_val = 4'(v); kk = 4'(k); z_bus = 4'(z);
    @(posedge clk);
    e_cp = 0;
    if (en) begin
      case (o)
        0: begin m_ra = z; m_mem[m_addr] ^= (m_ra << 4) | m_rb; end
        1: begin m_rb = z; m_mem[m_addr] ^= (m_ra << 4) | m_rb; end
        2, 3, 4, 5: begin
          if (o < 4) m_addr = (t << 8) | (u << 4) | v;
          else       m_addr = (3 << 8) | (k << 4) | v;
          m_ra = m_mem[m_addr] >> 4;
          m_rb = m_mem[m_addr] & 15;
          m_mem[m_addr] = 0;
          e_cp = (o == 2 || o == 4);
        end
        default: ;
      endcase
    end
    @(negedge clk);
    chk(tag, "ra", int'(ra), m_ra);
    chk(tag, "rb", int'(rb), m_rb);
    chk(tag, "mem_addr", int'(mem_addr), m_addr);
    chk((e_cp != 0) ? "R5" : tag, "ca_we", int'(ca_we), e_cp);
    chk((e_cp != 0) ? "R5" : tag, "cb_we", int'(cb_we), e_cp);
    if (e_cp != 0) begin
      chk("R5", "ca_data", int'(ca_data), m_ra);
      chk("R5", "cb_data", int'(cb_data), m_rb);
    end
    chk(tag, "ctl_stb", int'(ctl_stb), stb_of(en, o));
    chk(tag, "bad_op", int'(bad_op), (en && o >= 14) ? 1 : 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5519));
    for (int i = 0; i < 1024; i++) m_mem[i] = 0;
    m_ra = 0; m_rb = 0; m_addr = 0;
    rst_n = 1'b0; cyc_en = 1'b0; op = '0; t_lo = '0;
    u_val = '0; v_val = '0; kk = '0; z_bus = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1: reset state at the ports and zeroed array
    chk("R1", "ra", int'(ra), 0);
    chk("R1", "rb", int'(rb), 0);
    chk("R1", "mem_addr", int'(mem_addr), 0);
    chk("R1", "ca_we", int'(ca_we), 0);
    chk("R1", "ctl_stb", int'(ctl_stb), 0);
    chk("R1", "bad_op", int'(bad_op), 0);
    step(1, 3, 2, 9, 6, 0, 0, "R1");
    step(1, 5, 0, 0, 15, 15, 0, "R1");

    // R6/R7: fill a cleared byte, then read it back with copy (R2, R5)
    step(1, 3, 1, 4, 7, 0, 0);
    step(1, 0, 0, 0, 0, 0, 4'hA);
    step(1, 1, 0, 0, 0, 0, 4'h5);
    step(1, 2, 1, 4, 7, 0, 0);
    // R4: second read of the same location returns zero
    step(1, 3, 1, 4, 7, 0, 0, "R4");
    // R3: forced-high address, write then reread with copy
    step(1, 5, 0, 0, 3, 12, 0);
    step(1, 1, 0, 0, 0, 0, 4'h9);
    step(1, 0, 0, 0, 0, 0, 4'h6);
    step(1, 4, 0, 0, 3, 12, 0);
    step(1, 4, 0, 0, 3, 12, 0, "R4");
    // R8: every peripheral opcode and the no-op
    for (int o = 6; o <= 13; o++) step(1, o, 3, 15, 15, 15, 15);
    // R9: unassigned opcodes
    step(1, 14, 2, 2, 2, 2, 2);
    step(1, 15, 1, 1, 1, 1, 1);
    // R10: disabled cycles carrying write and read opcodes
    step(0, 0, 0, 0, 0, 0, 4'hF);
    step(0, 2, 3, 3, 3, 3, 3);

    // random mix over a narrow address pool
    for (int n = 0; n < 4000; n++) begin
      bit en;
      int o;
      en = ($urandom_range(0, 9) != 0);
      o  = $urandom_range(0, 15);
      if ($urandom_range(0, 1) == 0) o = $urandom_range(0, 5);
      step(en, o, $urandom_range(0, 3), $urandom_range(0, 1),
           $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 15));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule